// File: doc/BRIEF.md
# Warp Memory Transaction Coalescer

The coalescer accepts one memory instruction from a group of 32 lanes. Each lane supplies a byte address and an active bit, and the instruction as a whole supplies a word size, a load/store flag and a load mode. From these, the block works out the smallest set of aligned memory transactions that covers every byte that any active lane touches. It then issues those transactions one at a time on a valid/ready channel, lowest address first. Each transaction carries a mask of the lanes it serves.

The transaction granularity is chosen for each instruction. A caching load works in 128-byte lines. A non-caching load, a read-only load and every store work in 32-byte segments. Every transaction beyond the first is one more issue of the same instruction. When the last transaction has been taken, the block pulses a completion flag and reports the transaction count, which is the replay figure. Only after that does it accept the next instruction.

The control is a three-state machine:
- **IDLE** accepts an instruction. It moves to ISSUE when at least one lane is active, and to FINISH when no lane is active.
- **ISSUE** presents transactions. It moves to FINISH once the final transaction is taken.
- **FINISH** holds the completion pulse for one cycle and then returns to IDLE.

Top module: `wcoal`

## Requirements
- R1: A load with `in_store`=0 and `in_mode`=0 (caching) is coalesced into 128-byte lines. Every `tx_addr` is a multiple of 128 and `tx_line`=1.
- R2: A load with `in_mode`=1 (non-caching) or `in_mode`=2 (read-only) is coalesced into 32-byte segments. Every `tx_addr` is a multiple of 32 and `tx_line`=0.
- R3: A store (`in_store`=1) always uses 32-byte segments, whatever `in_mode` holds.
- R4: If the active lanes touch N distinct granules, exactly N transactions are issued. Each granule is issued once, and `tx_count` equals N at completion. For example, 32 aligned consecutive 4-byte words give 1 line or 4 segments, 32 identical addresses give 1, and a misaligned consecutive run gives 2 lines or 5 segments.
- R5: `in_size` encodes the word size: 0=1, 1=2, 2=4, 3=8 and 4=16 bytes. A word whose bytes span two granules marks both granules, and the lane appears in both masks.
- R6: Lanes with a 0 in `in_active` contribute no granule and appear in no mask. An instruction with no active lane issues no transaction and completes with `tx_count`=0.
- R7: Transactions come out in strictly ascending address order. `tx_lanes` has bit i set exactly when active lane i has a byte in that granule.
- R8: While `tx_valid` is high and `tx_ready` is low, the transaction outputs hold steady. `tx_last` is high only on the final transaction of the instruction.
- R9: `done` pulses for one cycle, in the cycle after the final transaction is taken (or after an empty instruction is accepted), with `tx_count` valid. `in_ready` stays low from acceptance through that cycle, and inputs offered during that time are ignored.
- R10: After reset, `in_ready`=1, `tx_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block is idle and takes an instruction |
| in_addr | input | 1024 | Lane byte addresses, lane i in bits [32i+31:32i] |
| in_active | input | 32 | Active-lane mask |
| in_size | input | 3 | Word size code (0..4 = 1..16 bytes) |
| in_store | input | 1 | 1 = store, 0 = load |
| in_mode | input | 2 | Load mode: 0 caching, 1 non-caching, 2 read-only |
| tx_valid | output | 1 | Transaction presented |
| tx_ready | input | 1 | Transaction taken |
| tx_addr | output | 32 | Aligned granule base address |
| tx_lanes | output | 32 | Lanes served by this transaction |
| tx_line | output | 1 | 1 = 128-byte line, 0 = 32-byte segment |
| tx_last | output | 1 | Final transaction of the instruction |
| done | output | 1 | Instruction fully issued |
| tx_count | output | 7 | Transactions issued for the instruction |

## Verification
The per-lane pending bits are the state most likely to go wrong. A pending bit that fails to clear repeats a granule address. A pending bit that is set wrongly adds a transaction or a lane-mask bit. Either error shows up at the port on the very next transaction after the handshake, as an out-of-order or duplicate `tx_addr`, and the count seen at `done` is off as well. A wrong granularity latch shows on the first transaction, through `tx_line` and the alignment of the address. The bench keeps a sorted model of the expected transactions and compares against it on every cycle while transactions are issuing, so any such error is reported in the cycle it first appears.

// File: rtl/wcoal_pkg.sv
package wcoal_pkg;
    localparam int LINE_SHIFT = 7;
    localparam int SEG_SHIFT  = 5;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ISSUE  = 2'd1,
        S_FINISH = 2'd2
    } wc_state_e;

    // Byte count minus one for a size code; codes above 4 behave as 16 bytes.
    function automatic logic [4:0] size_minus_one(input logic [2:0] code);
        logic [2:0] c;
        c = (code > 3'd4) ? 3'd4 : code;
        return 5'((5'd1 << c) - 5'd1);
    endfunction
endpackage

// File: rtl/wcoal_span.sv
module wcoal_span
    import wcoal_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic              line_mode,
    output logic [ADDR_W-1:0] g_lo,
    output logic [ADDR_W-1:0] g_hi
);
    logic [ADDR_W-1:0] last_byte;

    always_comb begin
        last_byte = addr + ADDR_W'(size_minus_one(size));
        if (line_mode) begin
            g_lo = addr      >> LINE_SHIFT;
            g_hi = last_byte >> LINE_SHIFT;
        end else begin
            g_lo = addr      >> SEG_SHIFT;
            g_hi = last_byte >> SEG_SHIFT;
        end
    end
endmodule

// File: rtl/wcoal_minpick.sv
module wcoal_minpick #(
    parameter int N_LANES = 32,
    parameter int ADDR_W  = 32
) (
    input  logic [N_LANES-1:0][ADDR_W-1:0] lo,
    input  logic [N_LANES-1:0][ADDR_W-1:0] hi,
    input  logic [N_LANES-1:0]             pend_lo,
    input  logic [N_LANES-1:0]             pend_hi,
    output logic [ADDR_W-1:0]              min_g,
    output logic [N_LANES-1:0]             hit_lo,
    output logic [N_LANES-1:0]             hit_hi,
    output logic                           none_left_after
);
    logic found;

    always_comb begin
        min_g = '1;
        found = 1'b0;
        for (int i = 0; i < N_LANES; i++) begin
            if (pend_lo[i] && (!found || lo[i] < min_g)) begin
                min_g = lo[i];
                found = 1'b1;
            end
            if (pend_hi[i] && (!found || hi[i] < min_g)) begin
                min_g = hi[i];
                found = 1'b1;
            end
        end
        for (int i = 0; i < N_LANES; i++) begin
            hit_lo[i] = pend_lo[i] && (lo[i] == min_g);
            hit_hi[i] = pend_hi[i] && (hi[i] == min_g);
        end
        none_left_after = ((pend_lo & ~hit_lo) | (pend_hi & ~hit_hi)) == '0;
    end
endmodule

// File: rtl/wcoal.sv
module wcoal
    import wcoal_pkg::*;
#(
    parameter int N_LANES = 32,
    parameter int ADDR_W  = 32,
    localparam int CNT_W  = $clog2(2 * N_LANES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [N_LANES*ADDR_W-1:0]   in_addr,
    input  logic [N_LANES-1:0]          in_active,
    input  logic [2:0]                  in_size,
    input  logic                        in_store,
    input  logic [1:0]                  in_mode,
    output logic                        tx_valid,
    input  logic                        tx_ready,
    output logic [ADDR_W-1:0]           tx_addr,
    output logic [N_LANES-1:0]          tx_lanes,
    output logic                        tx_line,
    output logic                        tx_last,
    output logic                        done,
    output logic [CNT_W-1:0]            tx_count
);
    wc_state_e state_q, state_d;

    logic                              line_now;
    logic [N_LANES-1:0][ADDR_W-1:0]    lo_now, hi_now;
    logic [N_LANES-1:0][ADDR_W-1:0]    lo_q, hi_q;
    logic [N_LANES-1:0]                pend_lo_q, pend_hi_q;
    logic [N_LANES-1:0]                act_q;
    logic                              line_q;
    logic [CNT_W-1:0]                  cnt_q;

    logic [ADDR_W-1:0]                 min_g;
    logic [N_LANES-1:0]                hit_lo, hit_hi;
    logic                              final_tx;
    logic                              accept, take;

    assign line_now = !in_store && (in_mode == 2'd0);

    for (genvar g = 0; g < N_LANES; g++) begin : g_span
        wcoal_span #(.ADDR_W(ADDR_W)) u_span (
            .addr      (in_addr[g*ADDR_W +: ADDR_W]),
            .size      (in_size),
            .line_mode (line_now),
            .g_lo      (lo_now[g]),
            .g_hi      (hi_now[g])
        );
    end

    wcoal_minpick #(.N_LANES(N_LANES), .ADDR_W(ADDR_W)) u_pick (
        .lo              (lo_q),
        .hi              (hi_q),
        .pend_lo         (pend_lo_q),
        .pend_hi         (pend_hi_q),
        .min_g           (min_g),
        .hit_lo          (hit_lo),
        .hit_hi          (hit_hi),
        .none_left_after (final_tx)
    );

    assign accept = in_valid && in_ready;
    assign take   = tx_valid && tx_ready;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = (in_active == '0) ? S_FINISH : S_ISSUE;
            S_ISSUE:  if (take && final_tx) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        in_ready = 1'b0;
        tx_valid = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            S_IDLE:   in_ready = 1'b1;
            S_ISSUE:  tx_valid = 1'b1;
            S_FINISH: done     = 1'b1;
            default:  ;
        endcase
        tx_addr  = line_q ? (min_g << LINE_SHIFT) : (min_g << SEG_SHIFT);
        tx_lanes = hit_lo | hit_hi;
        tx_line  = line_q;
        tx_last  = tx_valid && final_tx;
        tx_count = cnt_q;
    end

    // Instruction datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q      <= '0;
            hi_q      <= '0;
            pend_lo_q <= '0;
            pend_hi_q <= '0;
            act_q     <= '0;
            line_q    <= 1'b0;
            cnt_q     <= '0;
        end else if (accept) begin
            lo_q   <= lo_now;
            hi_q   <= hi_now;
            act_q  <= in_active;
            line_q <= line_now;
            cnt_q  <= '0;
            for (int i = 0; i < N_LANES; i++) begin
                pend_lo_q[i] <= in_active[i];
                pend_hi_q[i] <= in_active[i] && (hi_now[i] != lo_now[i]);
            end
        end else if (take) begin
            pend_lo_q <= pend_lo_q & ~hit_lo;
            pend_hi_q <= pend_hi_q & ~hit_hi;
            cnt_q     <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wcoal_chk.sv
module wcoal_chk #(
    parameter int N_LANES = 32,
    parameter int ADDR_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_ready,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [ADDR_W-1:0]  tx_addr,
    input logic [N_LANES-1:0] tx_lanes,
    input logic               tx_line,
    input logic               tx_last,
    input logic               done,
    input logic [N_LANES-1:0] act_q
);
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_addr) && $stable(tx_lanes) && $stable(tx_last)); // R8

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && !tx_last |=> tx_valid && (tx_addr > $past(tx_addr))); // R7

    AST_SEG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_line |-> tx_addr[4:0] == 5'd0); // R2

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_line |-> tx_addr[6:0] == 7'd0); // R1

    AST_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_lanes != '0) && ((tx_lanes & ~act_q) == '0)); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> done && !tx_valid); // R9

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid || done) |-> !in_ready); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
endmodule

bind wcoal wcoal_chk #(.N_LANES(N_LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_addr  (tx_addr),
    .tx_lanes (tx_lanes),
    .tx_line  (tx_line),
    .tx_last  (tx_last),
    .done     (done),
    .act_q    (act_q)
);

// File: tb/wcoal_tb.sv
module wcoal_tb;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1023:0] in_addr = '0;
    logic [31:0]   in_active = '0;
    logic [2:0]    in_size = '0;
    logic          in_store = 1'b0;
    logic [1:0]    in_mode = '0;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic [31:0]   tx_addr;
    logic [31:0]   tx_lanes;
    logic          tx_line;
    logic          tx_last;
    logic          done;
    logic [6:0]    tx_count;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [31:0] la [32];
    logic [31:0] exp_addr [$];
    logic [31:0] exp_mask [$];

    always #2 clk = ~clk;

    wcoal u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_active(in_active), .in_size(in_size),
        .in_store(in_store), .in_mode(in_mode), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_addr(tx_addr), .tx_lanes(tx_lanes),
        .tx_line(tx_line), .tx_last(tx_last), .done(done), .tx_count(tx_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: sorted map of granule -> lane mask.
    task automatic build_expect(input logic [31:0] act, input int sz,
                                input bit st, input int md);
        bit [31:0] gm [int unsigned];
        int unsigned k, lo, hi, sh;
        bit [31:0] m;
        sh = (!st && md == 0) ? 7 : 5;
        exp_addr.delete();
        exp_mask.delete();
        for (int i = 0; i < 32; i++) begin
            if (act[i]) begin
                lo = la[i] >> sh;
                hi = (la[i] + (32'd1 << sz) - 32'd1) >> sh;
                m = gm.exists(lo) ? gm[lo] : 32'd0; m[i] = 1'b1; gm[lo] = m;
                m = gm.exists(hi) ? gm[hi] : 32'd0; m[i] = 1'b1; gm[hi] = m;
            end
        end
        if (gm.first(k)) begin
            do begin
                exp_addr.push_back(k << sh);
                exp_mask.push_back(gm[k]);
            end while (gm.next(k));
        end
    endtask

    task automatic run(input string req, input logic [31:0] act, input int sz,
                       input bit st, input int md, input int stall, input bit noisy);
        int n, step;
        bit rdy, line_exp;
        string rl;
        build_expect(act, sz, st, md);
        n = exp_addr.size();
        line_exp = !st && md == 0;
        rl = st ? "R3" : (md == 0 ? "R1" : "R2");
        for (int i = 0; i < 32; i++) in_addr[i*32 +: 32] = la[i];
        in_active = act; in_size = 3'(sz); in_store = st; in_mode = 2'(md);
        @(negedge clk);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (noisy) begin
            in_addr = ~in_addr; in_active = '1; in_size = 3'd4;
        end else begin
            in_valid = 1'b0;
        end
        step = 0;
        while (exp_addr.size() != 0) begin
            chk(tx_valid === 1'b1, "R8", "tx_valid", 64'(tx_valid), 1);
            chk(in_ready === 1'b0, "R9", "in_ready busy", 64'(in_ready), 0);
            chk(tx_addr === exp_addr[0], "R7", "tx_addr", 64'(tx_addr), 64'(exp_addr[0]));
            chk(tx_lanes === exp_mask[0], "R7", "tx_lanes", 64'(tx_lanes), 64'(exp_mask[0]));
            chk(tx_last === (exp_addr.size() == 1), "R8", "tx_last", 64'(tx_last),
                64'(exp_addr.size() == 1));
            chk(tx_line === line_exp, rl, "tx_line", 64'(tx_line), 64'(line_exp));
            rdy = (stall == 0) || ((step % stall) != 1);
            if (exp_addr.size() == 1) in_valid = 1'b0;
            tx_ready = rdy;
            step++;
            @(posedge clk);
            @(negedge clk);
            tx_ready = 1'b0;
            if (rdy) begin
                void'(exp_addr.pop_front());
                void'(exp_mask.pop_front());
            end
        end
        in_valid = 1'b0;
        chk(done === 1'b1, "R9", "done", 64'(done), 1);
        chk(tx_valid === 1'b0, "R9", "tx_valid at done", 64'(tx_valid), 0);
        chk(tx_count === 7'(n), req, "tx_count", 64'(tx_count), 64'(n));
        @(negedge clk);
        chk(done === 1'b0 && in_ready === 1'b1, "R9", "back to idle",
            64'({done, in_ready}), 64'(2'b01));
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready === 1'b1 && tx_valid === 1'b0 && done === 1'b0, "R10", "reset outputs",
            64'({in_ready, tx_valid, done}), 64'(3'b100));
        rst_n = 1'b1;
        @(negedge clk);

        // R4: aligned consecutive 4-byte words: 1 line, then 4 segments
        for (int i = 0; i < 32; i++) la[i] = 32'h1000 + 32'(4 * i);
        run("R4", '1, 2, 0, 0, 0, 0);
        run("R4", '1, 2, 0, 1, 0, 0);
        // R4: misaligned run: 2 lines, 5 segments (read-only), with backpressure
        for (int i = 0; i < 32; i++) la[i] = 32'h2010 + 32'(4 * i);
        run("R4", '1, 2, 0, 0, 3, 0);
        run("R4", '1, 2, 0, 2, 2, 0);
        // R4: broadcast of one word gives a single transaction
        for (int i = 0; i < 32; i++) la[i] = 32'h3044;
        run("R4", '1, 2, 0, 0, 0, 0);
        run("R4", '1, 2, 0, 1, 0, 0);
        // R3: store with caching mode still uses segments
        for (int i = 0; i < 32; i++) la[i] = 32'h4000 + 32'(4 * i);
        run("R3", '1, 2, 1, 0, 0, 0);
        // R5: 16-byte words straddling segments; 8-, 2- and 1-byte words
        for (int i = 0; i < 32; i++) la[i] = 32'h5018 + 32'(40 * i);
        run("R5", '1, 4, 0, 1, 0, 0);
        for (int i = 0; i < 32; i++) la[i] = 32'h607C + 32'(64 * i);
        run("R5", '1, 3, 0, 0, 2, 0);
        for (int i = 0; i < 32; i++) la[i] = 32'h701F + 32'(32 * i);
        run("R5", '1, 1, 1, 2, 0, 0);
        for (int i = 0; i < 32; i++) la[i] = 32'h8000 + 32'(i);
        run("R5", '1, 0, 0, 1, 0, 0);
        // R7: descending, scattered addresses come out ascending
        for (int i = 0; i < 32; i++) la[i] = 32'h9F00 - 32'(i * 200) + 32'((i * 7) % 5);
        run("R7", '1, 2, 0, 0, 0, 0);
        // R6: inactive lanes far away contribute nothing
        for (int i = 0; i < 32; i++) la[i] = (i % 2 == 0) ? 32'hA000 + 32'(4 * i) : 32'hF000_0000;
        run("R6", 32'h5555_5555, 2, 0, 1, 0, 0);
        // R6: no active lanes
        run("R6", 32'h0, 2, 0, 1, 0, 0);
        // R9: inputs changed and held valid while busy are ignored
        for (int i = 0; i < 32; i++) la[i] = 32'hB000 + 32'(12 * i);
        run("R9", 32'h00FF_F00F, 2, 0, 1, 2, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule